// File: doc/BRIEF.md
# Configurable Edge Interrupt Line Controller

This block watches a bank of external event lines and turns a chosen edge on each line into an interrupt request. Each line is sampled through a short synchronizer, and its edge is found by comparing the newest sample with the one before it. Software picks whether the line reacts to a rising edge, a falling edge, both, or neither. Software can also inject a one-shot trigger on any line as if an active edge had arrived.

A triggered line that is unmasked latches a pending flag. The line's interrupt request stays high while that flag is set and the line is unmasked. The service routine clears the flag by writing a one to its bit. Each line also drives a one-cycle trigger pulse for event and wakeup logic. A single wake request output is high while any line is triggering or any flag is pending.

Configuration goes through a simple synchronous register port. Writes take effect on the clock edge, and reads are combinational from the current address.

Top module: `eil_ctrl`

## Requirements
- R1: After reset, every register reads zero and `trig_pulse`, `irq` and `wake_req` are low.
- R2: With a line's rising select bit (offset 0) set, a low-to-high change on its input that is first sampled at clock edge k drives that line's `trig_pulse` bit high for exactly the cycle between edges k+1 and k+2. A falling change on a line with only the rising select set gives no pulse.
- R3: With a line's falling select bit (offset 1) set, a high-to-low change gives the same one-cycle pulse with the same latency as in R2. A rising change on a line with only the falling select set gives no pulse.
- R4: With both select bits set, a line pulses on either edge. With neither set, the line never pulses from its input.
- R5: Writing 1 to a bit at offset 2 pulses that line's `trig_pulse` for the one cycle after the write edge, whatever the edge selects are. The bit then clears itself, so offset 2 reads zero afterwards. Bits written 0 have no effect.
- R6: A trigger sets the line's pending flag (offset 4) at the next clock edge only if the line's mask bit (offset 3, 1 = enabled) is set. Masked triggers leave the flag clear.
- R7: `irq` for a line is high exactly while its pending flag is set and its mask bit is set. Masking a pending line drops `irq` but keeps the flag.
- R8: A pending flag stays set until software writes 1 to its bit at offset 4. Writing 0 to a bit leaves it unchanged.
- R9: When a trigger that would set a line's flag and a write-one clear of that same line land on the same clock edge, the flag stays set.
- R10: `wake_req` is high whenever any line's trigger pulse is high or any pending flag is set, and low otherwise.
- R11: Offsets 0, 1 and 3 read back what was last written. Offset 4 reads the pending flags. Offsets 5 to 7 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | N | External event lines, sampled through a synchronizer |
| reg_addr | input | 3 | Register word offset |
| reg_wr | input | 1 | Write strobe, takes effect on the clock edge |
| reg_wdata | input | N | Write data, one bit per line |
| reg_rdata | output | N | Read data for `reg_addr`, combinational |
| trig_pulse | output | N | One-cycle per-line trigger pulse for event and wakeup logic |
| irq | output | N | Per-line interrupt request, level |
| wake_req | output | 1 | Any line triggering or pending |

## Verification
The lines are set up in four ways so that the edge selection is tried in each combination. One line is rising-only, one is falling-only, one has both selects and one has neither, and each of them is driven with both edge directions. A pulse on the wrong direction, or a missing pulse, therefore points to the select decoding. A fifth line is rising-enabled but masked. It shows that the trigger pulse and the pending flag are gated separately.

Software triggers are injected on a line that has no edge select set. This separates the injection path from the edge path. Write-one clears are tried with zero data, with a one, and on the same edge as a trigger to the same line. Together these expose a flag that clears on a zero, one that never clears, and one where the clear wins over the set.

// File: rtl/eil_pkg.sv
package eil_pkg;
  localparam int unsigned AW = 3;
  localparam logic [AW-1:0] OFS_RISE = 3'd0;
  localparam logic [AW-1:0] OFS_FALL = 3'd1;
  localparam logic [AW-1:0] OFS_SWT  = 3'd2;
  localparam logic [AW-1:0] OFS_MASK = 3'd3;
  localparam logic [AW-1:0] OFS_PEND = 3'd4;

  // edge hit of one line from two consecutive samples
  function automatic logic line_hit(logic cur, logic prev, logic rsel, logic fsel);
    return (rsel & cur & ~prev) | (fsel & ~cur & prev);
  endfunction

  // next value of one pending flag; a set beats a same-edge clear
  function automatic logic pend_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/eil_edge_det.sv
module eil_edge_det
  import eil_pkg::*;
#(
  parameter int unsigned N           = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_in,
  input  logic [N-1:0] rise_sel,
  input  logic [N-1:0] fall_sel,
  output logic [N-1:0] hw_hit
);
  for (genvar gi = 0; gi < N; gi++) begin : g_line
    logic [SYNC_STAGES-1:0] sh_q;
    logic                   prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q   <= '0;
        prev_q <= 1'b0;
      end else begin
        sh_q   <= {sh_q[SYNC_STAGES-2:0], line_in[gi]};
        prev_q <= sh_q[SYNC_STAGES-1];
      end
    end

    assign hw_hit[gi] = line_hit(sh_q[SYNC_STAGES-1], prev_q, rise_sel[gi], fall_sel[gi]);
  end
endmodule

// File: rtl/eil_regfile.sv
module eil_regfile
  import eil_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [N-1:0]  reg_wdata,
  input  logic [N-1:0]  pend,
  output logic [N-1:0]  reg_rdata,
  output logic [N-1:0]  rise_sel,
  output logic [N-1:0]  fall_sel,
  output logic [N-1:0]  mask,
  output logic [N-1:0]  sw_q,
  output logic [N-1:0]  pend_clr,
  output logic          sw_wr
);
  logic wr_rise, wr_fall, wr_mask, wr_pend;

  assign wr_rise = reg_wr && (reg_addr == OFS_RISE);
  assign wr_fall = reg_wr && (reg_addr == OFS_FALL);
  assign wr_mask = reg_wr && (reg_addr == OFS_MASK);
  assign wr_pend = reg_wr && (reg_addr == OFS_PEND);
  assign sw_wr   = reg_wr && (reg_addr == OFS_SWT);

  assign pend_clr = wr_pend ? reg_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_sel <= '0;
      fall_sel <= '0;
      mask     <= '0;
      sw_q     <= '0;
    end else begin
      if (wr_rise) rise_sel <= reg_wdata;
      if (wr_fall) fall_sel <= reg_wdata;
      if (wr_mask) mask     <= reg_wdata;
      // software trigger lives one cycle and clears itself
      sw_q <= sw_wr ? reg_wdata : '0;
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFS_RISE: reg_rdata = rise_sel;
      OFS_FALL: reg_rdata = fall_sel;
      OFS_SWT:  reg_rdata = sw_q;
      OFS_MASK: reg_rdata = mask;
      OFS_PEND: reg_rdata = pend;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/eil_pend.sv
module eil_pend
  import eil_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] trig,
  input  logic [N-1:0] mask,
  input  logic [N-1:0] clr,
  output logic [N-1:0] set,
  output logic [N-1:0] pend
);
  assign set = trig & mask;

  for (genvar gi = 0; gi < N; gi++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend[gi] <= 1'b0;
      else        pend[gi] <= pend_next(pend[gi], set[gi], clr[gi]);
    end
  end
endmodule

// File: rtl/eil_ctrl.sv
module eil_ctrl
  import eil_pkg::*;
#(
  parameter int unsigned N           = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  line_in,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [N-1:0]  reg_wdata,
  output logic [N-1:0]  reg_rdata,
  output logic [N-1:0]  trig_pulse,
  output logic [N-1:0]  irq,
  output logic          wake_req
);
  logic [N-1:0] rise_sel, fall_sel, mask_q, sw_q;
  logic [N-1:0] hw_hit, trig, pend_q, pend_set, pend_clr;
  logic         sw_wr;

  eil_edge_det #(.N(N), .SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_in  (line_in),
    .rise_sel (rise_sel),
    .fall_sel (fall_sel),
    .hw_hit   (hw_hit)
  );

  eil_regfile #(.N(N)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .pend      (pend_q),
    .reg_rdata (reg_rdata),
    .rise_sel  (rise_sel),
    .fall_sel  (fall_sel),
    .mask      (mask_q),
    .sw_q      (sw_q),
    .pend_clr  (pend_clr),
    .sw_wr     (sw_wr)
  );

  // software trigger merges with the edge before the mask
  assign trig = hw_hit | sw_q;

  eil_pend #(.N(N)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .trig  (trig),
    .mask  (mask_q),
    .clr   (pend_clr),
    .set   (pend_set),
    .pend  (pend_q)
  );

  assign trig_pulse = trig;
  assign irq        = pend_q & mask_q;
  assign wake_req   = |(trig | pend_q);
endmodule

// File: rtl/eil_ctrl_chk.sv
module eil_ctrl_chk #(
  parameter int unsigned N = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] irq,
  input logic         wake_req,
  input logic [N-1:0] pend,
  input logic [N-1:0] mask,
  input logic [N-1:0] clr,
  input logic [N-1:0] set,
  input logic [N-1:0] sw_q,
  input logic         sw_wr
);
  // R6, R9: an enabled trigger always leaves its flag set, even against a clear
  p_set_sticks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((pend & $past(set)) == $past(set)));

  // R6: a flag only appears on a line that was unmasked
  p_masked_no_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(mask)) == '0));

  // R8: a flag that was not cleared cannot drop
  p_pend_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend) & ~$past(clr) & ~pend) == '0));

  // R7: a request stays up while its line remains unmasked and uncleared
  p_irq_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(irq) & ~$past(clr) & mask & ~irq) == '0));

  // R5: the software trigger clears itself when no new write follows
  p_sw_selfclear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_q != '0) && !sw_wr) |=> (sw_q == '0));

  // R10: a freshly set flag keeps the wake request high
  p_wake_on_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> wake_req);
endmodule

bind eil_ctrl eil_ctrl_chk #(.N(N)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq      (irq),
  .wake_req (wake_req),
  .pend     (pend_q),
  .mask     (mask_q),
  .clr      (pend_clr),
  .set      (pend_set),
  .sw_q     (sw_q),
  .sw_wr    (sw_wr)
);

// File: tb/test_eil_ctrl.sv
module test_eil_ctrl;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  line_in = '0;
  logic [2:0]    reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [N-1:0]  reg_wdata = '0;
  logic [N-1:0]  reg_rdata, trig_pulse, irq;
  logic          wake_req;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  eil_ctrl #(.N(N)) i_eil_ctrl (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .trig_pulse(trig_pulse), .irq(irq), .wake_req(wake_req)
  );

  // {addr, write data, expected read-back}
  localparam logic [34:0] VT [7] = '{
    {3'd0, 16'hA5A5, 16'hA5A5},   // R11 rising select
    {3'd1, 16'h0F0F, 16'h0F0F},   // R11 falling select
    {3'd3, 16'hFFFF, 16'hFFFF},   // R11 mask
    {3'd5, 16'h1234, 16'h0000},   // R11 unmapped
    {3'd7, 16'hFFFF, 16'h0000},   // R11 unmapped
    {3'd4, 16'hFFFF, 16'h0000},   // R8 clear with nothing pending
    {3'd2, 16'h0000, 16'h0000}    // R5 zero write injects nothing
  };

  task automatic chk(string req, logic [N-1:0] got, logic [N-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [2:0] a, logic [N-1:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [N-1:0] v);
    reg_addr = a;
    #0.5;
    v = reg_rdata;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : main
    logic [N-1:0] v;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    chk("R1 trig", trig_pulse, '0);
    chk("R1 irq", irq, '0);
    chk("R1 wake", {15'd0, wake_req}, '0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 regs", v, '0);
    end

    // register table
    for (int i = 0; i < 7; i++) begin
      wr(VT[i][34:32], VT[i][31:16]);
      rd(VT[i][34:32], v);
      chk("R11 table", v, VT[i][15:0]);
      chk("R5 table no trigger", trig_pulse, '0);
    end

    // line0 rise, line1 both, line2 fall, line3 none, line4 rise but masked
    wr(3'd0, 16'h0013);
    wr(3'd1, 16'h0006);
    wr(3'd3, 16'hFFEF);

    // R2 rising on line0
    line_in[0] = 1'b1;
    step(1); chk("R2 before", trig_pulse, '0);
    step(1); chk("R2 pulse", trig_pulse, 16'h0001);
    chk("R10 wake on trig", {15'd0, wake_req}, 16'h1);
    rd(3'd4, v); chk("R6 not yet pending", v, '0);
    step(1); chk("R2 one cycle", trig_pulse, '0);
    chk("R7 irq", irq, 16'h0001);
    rd(3'd4, v); chk("R6 pending", v, 16'h0001);
    line_in[0] = 1'b0;
    step(3); chk("R2 no fall pulse", trig_pulse, '0);
    chk("R8 stays pending", irq, 16'h0001);
    wr(3'd4, 16'h0001);
    chk("R8 cleared", irq, '0);
    chk("R10 wake idle", {15'd0, wake_req}, '0);

    // R3 falling on line2
    line_in[2] = 1'b1;
    step(1); step(1); chk("R3 no rise pulse", trig_pulse, '0);
    step(2);
    line_in[2] = 1'b0;
    step(1); chk("R3 before", trig_pulse, '0);
    step(1); chk("R3 pulse", trig_pulse, 16'h0004);
    step(1); chk("R3 one cycle", trig_pulse, '0);
    chk("R3 irq", irq, 16'h0004);
    wr(3'd4, 16'h0004);

    // R4 both edges on line1
    line_in[1] = 1'b1;
    step(2); chk("R4 rise", trig_pulse, 16'h0002);
    step(1); wr(3'd4, 16'h0002);
    line_in[1] = 1'b0;
    step(2); chk("R4 fall", trig_pulse, 16'h0002);
    step(1); wr(3'd4, 16'h0002);
    chk("R4 cleared", irq, '0);

    // R4 neither on line3
    line_in[3] = 1'b1;
    step(2); chk("R4 none rise", trig_pulse, '0);
    step(1); line_in[3] = 1'b0;
    step(2); chk("R4 none fall", trig_pulse, '0);
    step(1); rd(3'd4, v); chk("R4 none pending", v, '0);

    // R6 masked line4
    line_in[4] = 1'b1;
    step(2); chk("R6 masked pulse", trig_pulse, 16'h0010);
    step(1); rd(3'd4, v); chk("R6 masked no pend", v, '0);
    chk("R6 masked no irq", irq, '0);
    chk("R10 wake after masked", {15'd0, wake_req}, '0);
    line_in[4] = 1'b0;
    step(3);

    // R5 software trigger on line8
    wr(3'd2, 16'h0100);
    chk("R5 sw pulse", trig_pulse, 16'h0100);
    step(1);
    chk("R5 one cycle", trig_pulse, '0);
    rd(3'd2, v); chk("R5 self clear", v, '0);
    chk("R5 irq", irq, 16'h0100);
    chk("R10 wake pending", {15'd0, wake_req}, 16'h1);

    // R7 masking a pending line
    wr(3'd3, 16'hFEEF);
    chk("R7 masked irq low", irq, '0);
    rd(3'd4, v); chk("R7 flag kept", v, 16'h0100);
    wr(3'd3, 16'hFFEF);
    chk("R7 irq back", irq, 16'h0100);

    // R8 write zero then one
    wr(3'd4, 16'h0000);
    rd(3'd4, v); chk("R8 zero write", v, 16'h0100);
    wr(3'd4, 16'h0100);
    rd(3'd4, v); chk("R8 one write", v, '0);

    // R5 sw trigger on masked line4
    wr(3'd2, 16'h0010);
    chk("R5 masked sw pulse", trig_pulse, 16'h0010);
    step(1); rd(3'd4, v); chk("R6 masked sw no pend", v, '0);

    // R9 set and clear on the same edge
    wr(3'd2, 16'h0008);
    wr(3'd4, 16'h0008);
    rd(3'd4, v); chk("R9 set wins", v, 16'h0008);
    wr(3'd4, 16'h0008);
    rd(3'd4, v); chk("R9 later clear", v, '0);
    chk("R10 final wake", {15'd0, wake_req}, '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule